// File: doc/BRIEF.md
# Serial Bus Status Flags With Two-Step Acknowledge

This block holds the status flags of a single-wire serial bus transceiver. It keeps three sticky flags: receive-data-full, bit error and noise. The serial engine raises each flag with a one-cycle set strobe. The receive-full strobe fires every time a received byte moves from the shift register into the data register, and a strobe fires again even when the flag is already set. The block detects bit errors itself. While a push field is being driven, it compares each transmitted bit with the level sampled back from the bus.

Software acknowledges flags through the CPU read port in two steps. A read of the status address takes a snapshot of the flags. A later read of the data address clears exactly the flags held in that snapshot. A flag that rose after the status read therefore survives and is seen on the next status read. The interrupt request follows the receive-full flag, gated by an enable and delayed one register. A bit error never raises it.

Top module: `serial_status_flags`

## Requirements
- R1: After reset the status byte reads 8'hC0, all flags are 0 and `irq` is 0.
- R2: A status-address read returns {1,1,rx_full,0,bit_err,noise,0,0}, with receive-full at bit 5, bit error at bit 3 and noise at bit 2. A read of any other address, or no read, returns 8'h00 on `rd_data`.
- R3: A `rx_full_set` pulse sets receive-full from the next cycle. Repeated pulses keep it set.
- R4: Bit error sets when `push_active` and `bit_sample` are high and `tx_bit` differs from `bus_bit`. A match, or a mismatch outside a sampled push field, has no effect.
- R5: A `noise_set` pulse sets the noise flag from the next cycle.
- R6: Flags clear only on a data-address read. A data read with no status read before it clears nothing.
- R7: A data read clears only the flags that were 1 at the most recent status read. A flag set after that read stays set.
- R8: A set event in the same cycle as a clearing data read leaves the flag set.
- R9: A second status read before the data read replaces the snapshot with the current flags.
- R10: `irq` equals receive-full AND `rx_irq_en` from the previous cycle. Bit error and noise never drive `irq`.
- R11: A data read uses up the snapshot, so a further data read without a new status read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | ADDR_W | CPU read address |
| rd_data | output | 8 | Status byte on status reads, else zero |
| rx_full_set | input | 1 | Received byte transferred to the data register |
| noise_set | input | 1 | Noise detected on a received bit |
| push_active | input | 1 | A push field is being driven |
| bit_sample | input | 1 | Bus readback sample point |
| tx_bit | input | 1 | Bit currently driven |
| bus_bit | input | 1 | Bus level sampled back |
| rx_irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Registered receive interrupt request |

## Verification
The hardest case to reach is a flag that rises in the gap between the status read and the data read, because the clear must then spare it. The same applies to a set strobe that lands in the very cycle of the data read. Directed sequences place the strobes in exactly those cycles. Random traffic then mixes reads of both addresses with set strobes and bus mismatches, so that repeated status reads, stale snapshots and double data reads arise many times.

// File: rtl/serial_status_flags.sv
module serial_status_flags #(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              rx_full_set,
  input  logic              noise_set,
  input  logic              push_active,
  input  logic              bit_sample,
  input  logic              tx_bit,
  input  logic              bus_bit,
  input  logic              rx_irq_en,
  output logic              irq
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] flag_q, snap_q, set_vec;
  logic st_rd, dt_rd, err_evt;

  assign st_rd   = rd_en && (rd_addr == STATUS_ADDR);
  assign dt_rd   = rd_en && (rd_addr == DATA_ADDR);
  assign err_evt = push_active && bit_sample && (tx_bit != bus_bit);
  assign set_vec = {rx_full_set, err_evt, noise_set};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      snap_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= (dt_rd ? (flag_q & ~snap_q) : flag_q) | set_vec;
      if (st_rd)      snap_q <= flag_q;
      else if (dt_rd) snap_q <= '0;
      irq <= flag_q[2] & rx_irq_en;
    end
  end

  assign rd_data = st_rd ? {2'b11, flag_q[2], 1'b0, flag_q[1], flag_q[0], 2'b00} : 8'h00;
endmodule

module serial_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dt_rd,
  input logic       rx_full_set,
  input logic       err_evt,
  input logic       rx_irq_en,
  input logic [2:0] flag_q,
  input logic [2:0] snap_q,
  input logic       irq
);
  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_set |=> flag_q[2]);
  assert_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dt_rd && flag_q[1]) |=> flag_q[1]);
  assert_keep_unsnapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_rd && flag_q[0] && !snap_q[0]) |=> flag_q[0]);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_rd && err_evt) |=> flag_q[1]);
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(flag_q[2]) && $past(rx_irq_en)));
endmodule

bind serial_status_flags serial_status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dt_rd(dt_rd), .rx_full_set(rx_full_set),
  .err_evt(err_evt), .rx_irq_en(rx_irq_en), .flag_q(flag_q),
  .snap_q(snap_q), .irq(irq)
);

// File: tb/sim_serial_status_flags.sv
module sim_serial_status_flags;
  localparam int PERIOD = 10;
  localparam logic [1:0] ST = 2'd0, DT = 2'd1;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, rx_full_set = 0, noise_set = 0, push_active = 0;
  logic bit_sample = 0, tx_bit = 0, bus_bit = 0, rx_irq_en = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0, fails = 0;
  logic [2:0] m_flag = 0, m_snap = 0;
  logic m_irq = 0;

  always #(PERIOD/2) clk = ~clk;

  serial_status_flags u0 (.*);

  function automatic logic [7:0] exp_byte(logic rd, logic [1:0] a, logic [2:0] f);
    return (rd && a == ST) ? {2'b11, f[2], 1'b0, f[1], f[0], 2'b00} : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(string req, logic rd, logic [1:0] a, logic rs, logic ns,
                     logic pa, logic bs, logic tb, logic bb, logic en);
    logic [2:0] setv;
    @(negedge clk);
    rd_en = rd; rd_addr = a; rx_full_set = rs; noise_set = ns;
    push_active = pa; bit_sample = bs; tx_bit = tb; bus_bit = bb; rx_irq_en = en;
    #1;
    chk(req, rd_data, exp_byte(rd, a, m_flag));
    chk("R10", {7'd0, irq}, {7'd0, m_irq});
    setv = {rs, pa && bs && (tb != bb), ns};
    m_irq = m_flag[2] & en;
    if (rd && a == DT) begin
      m_flag = (m_flag & ~m_snap) | setv;
      m_snap = 0;
    end else begin
      if (rd && a == ST) m_snap = m_flag;
      m_flag = m_flag | setv;
    end
  endtask

  task automatic idle(); cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rds(string r); cyc(r, 1, ST, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rdd(string r); cyc(r, 1, DT, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rds("R1");
    chk("R1", {7'd0, irq}, 8'd0);
    // R3 set and repeat
    cyc("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rds("R3");
    rdd("R6");
    rds("R3");
    // R4 match / unsampled mismatch ignored, then real mismatch
    cyc("R4", 0, 0, 0, 0, 1, 1, 1, 1, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0, 1, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    rds("R4");
    cyc("R4", 0, 0, 0, 0, 1, 1, 0, 1, 0);
    rds("R4");
    // R10 bit error alone gives no irq
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    rdd("R4");
    rds("R10");
    // R5 noise, R6 data read alone does not clear
    cyc("R5", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    rdd("R6");
    rds("R6");
    // R7 flag set between the reads survives
    cyc("R7", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rds("R7");
    cyc("R7", 0, 0, 0, 0, 1, 1, 1, 0, 0);
    rdd("R7");
    rds("R7");
    // R8 set in clearing cycle
    cyc("R8", 1, DT, 1, 0, 0, 0, 0, 0, 0);
    rds("R8");
    // R9 second status read refreshes snapshot
    rdd("R9");
    cyc("R9", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rds("R9");
    cyc("R9", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    rds("R9");
    rdd("R9");
    rds("R9");
    // R11 snapshot used up
    cyc("R11", 0, 0, 1, 1, 0, 0, 0, 0, 0);
    rds("R11");
    rdd("R11");
    cyc("R11", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rdd("R11");
    rds("R11");
    // R10 irq follows enable
    cyc("R10", 0, 0, 1, 0, 0, 0, 0, 0, 1);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc("R7", r < 6, (r[0] ? DT : (r[1] ? ST : 2'd2)),
          ($urandom % 8) == 0, ($urandom % 10) == 0, 1'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle();
    finish_run();
  end
endmodule